// File: doc/BRIEF.md
# Product-Term Array with Term Disable

This block is the sum-of-products front end that feeds eight output macrocells. It takes a flat vector of AND-array fuses and a vector of per-row disable bits from a configuration store. From these it evaluates 64 product terms. Each product term is the AND of any chosen subset of 32 literals, and the literals are the true and complement forms of 16 array inputs. The rows are grouped eight to a macrocell, so macrocell m receives rows 8m to 8m+7. The OR gate and the output logic stay inside the macrocells and are not part of this block.

Eight of the 16 array inputs always come from eight dedicated input pins. The other eight are feedback columns, one for each macrocell. A global mode decides what drives each feedback column: the macrocell's own feedback, the macrocell's neighbour, or one of the two outer dedicated pins. The block has no state. Every output is a combinational function of the configuration, the mode and the pin and feedback values.

Top module: `pta_term_array`

## Requirements
- R1: Row r uses the fuse slice `and_fuse_i[32*r +: 32]`. Column 2j carries array input j in true form and column 2j+1 carries it in complement form. A fuse value of 1 (intact) keeps its literal in the AND, and a fuse value of 0 (blown) drops it. `term_o[r]` is the AND of the literals kept in that row.
- R2: A row whose 32 fuses are all intact always evaluates to 0, whatever the inputs.
- R3: An enabled row whose 32 fuses are all blown evaluates to 1.
- R4: `term_off_i[r]=1` forces `term_o[r]` to 0 whatever the fuses and inputs are.
- R5: Row r drives `term_o[r]` and no other output bit. Macrocell m owns rows 8m..8m+7, so its fuse group starts at fuse 256*m.
- R6: Array inputs 0..7 are `ded_i[1]..ded_i[8]` in every mode.
- R7: In registered mode (`mode_i` 2'b10, with 2'b11 treated the same), array input 8+k is `fb_i[k]`. `ded_i[0]` and `ded_i[9]` have no effect on any term in this mode.
- R8: In complex mode (`mode_i`=2'b01), array input 8 is `ded_i[0]` and array input 15 is `ded_i[9]`. Array inputs 9..14 are `fb_i[1]..fb_i[6]`. `fb_i[0]` and `fb_i[7]` have no effect on any term in this mode.
- R9: In simple mode (`mode_i`=2'b00), array input 8 is `ded_i[0]` and array input 15 is `ded_i[9]`. Array inputs 9..11 take the neighbour values `fb_i[0]..fb_i[2]`, and array inputs 12..14 take `fb_i[5]..fb_i[7]`. The two inner cells, `fb_i[3]` and `fb_i[4]`, have no effect on any term in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| and_fuse_i | input | 2048 | AND-array fuses; bit 32*r+c is row r, column c; 1 = intact |
| term_off_i | input | 64 | Per-row disable; 1 forces that product term to 0 |
| mode_i | input | 2 | Global routing mode: 00 simple, 01 complex, 10/11 registered |
| ded_i | input | 10 | Dedicated pins; bit 0 and bit 9 are the two outer pins |
| fb_i | input | 8 | Per-macrocell feedback values; bits 0 and 7 are the outer cells, 3 and 4 the inner |
| term_o | output | 64 | Product terms; bits 8m..8m+7 belong to macrocell m |

## Verification
Three fixed fuse patterns settle the array's boundary values. With every fuse intact each term must read 0. With every fuse blown each term must read 1, except where a disable bit forces it to 0. A single all-blown row placed in a field of intact rows shows that each row lands on its own output bit and on no other. A fuse map in which each of 32 rows keeps exactly one literal turns the terms into a readout of the array inputs, so random pin and feedback values in each mode tell a wrong column route apart from a wrong polarity. Toggling the pins that a mode leaves unused then shows whether any term changes. Finally, sparse random fuse maps with two to five kept literals per row, under random inputs and modes, are compared against a behavioural sum-of-products model.

// File: rtl/pta_pkg.sv
package pta_pkg;
  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'b00,
    MODE_COMPLEX = 2'b01,
    MODE_REG     = 2'b10,
    MODE_REG_ALT = 2'b11
  } pta_mode_e;
endpackage

// File: rtl/pta_input_router.sv
module pta_input_router
  import pta_pkg::*;
#(
  parameter  int N_CELLS = 8,
  localparam int N_DED   = N_CELLS + 2,
  localparam int N_IN    = 2 * N_CELLS
) (
  input  logic [1:0]         mode_i,
  input  logic [N_DED-1:0]   ded_i,
  input  logic [N_CELLS-1:0] fb_i,
  output logic [N_IN-1:0]    arr_in_o
);
  localparam int HALF = N_CELLS / 2;

  logic [N_CELLS-1:0] simple_col;
  logic [N_CELLS-1:0] complex_col;
  logic [N_CELLS-1:0] fb_col;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_col
    if (k == 0) begin : g_first
      assign simple_col[k]  = ded_i[0];
      assign complex_col[k] = ded_i[0];
    end else if (k == N_CELLS - 1) begin : g_last
      assign simple_col[k]  = ded_i[N_DED-1];
      assign complex_col[k] = ded_i[N_DED-1];
    end else if (k < HALF) begin : g_upper
      // neighbour toward the outer edge feeds this column
      assign simple_col[k]  = fb_i[k-1];
      assign complex_col[k] = fb_i[k];
    end else begin : g_lower
      assign simple_col[k]  = fb_i[k+1];
      assign complex_col[k] = fb_i[k];
    end
  end

  always_comb begin
    case (mode_i)
      MODE_SIMPLE:  fb_col = simple_col;
      MODE_COMPLEX: fb_col = complex_col;
      default:      fb_col = fb_i;
    endcase
  end

  assign arr_in_o = {fb_col, ded_i[N_CELLS:1]};
endmodule

// File: rtl/pta_literal_gen.sv
module pta_literal_gen #(
  parameter  int N_IN   = 16,
  localparam int N_COLS = 2 * N_IN
) (
  input  logic [N_IN-1:0]   arr_in_i,
  output logic [N_COLS-1:0] lit_o
);
  for (genvar j = 0; j < N_IN; j++) begin : g_lit
    assign lit_o[2*j]   = arr_in_i[j];
    assign lit_o[2*j+1] = ~arr_in_i[j];
  end
endmodule

// File: rtl/pta_term_row.sv
module pta_term_row #(
  parameter int N_COLS = 32
) (
  input  logic [N_COLS-1:0] lit_i,
  input  logic [N_COLS-1:0] fuse_i,
  input  logic              off_i,
  output logic              term_o
);
  // blown fuse (0) masks its literal to 1
  assign term_o = ~off_i & (&(lit_i | ~fuse_i));
endmodule

// File: rtl/pta_term_array.sv
module pta_term_array #(
  parameter  int N_CELLS        = 8,
  parameter  int TERMS_PER_CELL = 8,
  localparam int N_ROWS         = N_CELLS * TERMS_PER_CELL,
  localparam int N_IN           = 2 * N_CELLS,
  localparam int N_COLS         = 2 * N_IN,
  localparam int N_FUSE         = N_ROWS * N_COLS,
  localparam int N_DED          = N_CELLS + 2
) (
  input  logic [N_FUSE-1:0]  and_fuse_i,
  input  logic [N_ROWS-1:0]  term_off_i,
  input  logic [1:0]         mode_i,
  input  logic [N_DED-1:0]   ded_i,
  input  logic [N_CELLS-1:0] fb_i,
  output logic [N_ROWS-1:0]  term_o
);
  logic [N_IN-1:0]   arr_in;
  logic [N_COLS-1:0] lit;

  pta_input_router #(.N_CELLS(N_CELLS)) u_router (
    .mode_i   (mode_i),
    .ded_i    (ded_i),
    .fb_i     (fb_i),
    .arr_in_o (arr_in)
  );

  pta_literal_gen #(.N_IN(N_IN)) u_lit (
    .arr_in_i (arr_in),
    .lit_o    (lit)
  );

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    pta_term_row #(.N_COLS(N_COLS)) u_row (
      .lit_i  (lit),
      .fuse_i (and_fuse_i[r*N_COLS +: N_COLS]),
      .off_i  (term_off_i[r]),
      .term_o (term_o[r])
    );
  end
endmodule

// File: rtl/pta_term_array_chk.sv
module pta_term_array_chk #(
  parameter  int N_CELLS        = 8,
  parameter  int TERMS_PER_CELL = 8,
  localparam int N_ROWS         = N_CELLS * TERMS_PER_CELL,
  localparam int N_IN           = 2 * N_CELLS,
  localparam int N_COLS         = 2 * N_IN,
  localparam int N_FUSE         = N_ROWS * N_COLS,
  localparam int N_DED          = N_CELLS + 2
) (
  input logic [N_FUSE-1:0]  and_fuse_i,
  input logic [N_ROWS-1:0]  term_off_i,
  input logic [1:0]         mode_i,
  input logic [N_DED-1:0]   ded_i,
  input logic [N_CELLS-1:0] fb_i,
  input logic [N_ROWS-1:0]  term_o
);
  logic [N_COLS-1:0] slice;
  always_comb begin
    slice = '0;
    if (!$isunknown({and_fuse_i, term_off_i, mode_i, ded_i, fb_i, term_o})) begin
      for (int r = 0; r < N_ROWS; r++) begin
        slice = and_fuse_i[r*N_COLS +: N_COLS];
        if (term_off_i[r])
          a_r4_disabled_row_low: assert (!term_o[r]) else $error("R4 row %0d", r);
        if (&slice)
          a_r2_intact_row_low: assert (!term_o[r]) else $error("R2 row %0d", r);
        if (slice == '0 && !term_off_i[r])
          a_r3_blown_row_high: assert (term_o[r]) else $error("R3 row %0d", r);
        if ($countones(slice) == 1 && slice[0] && !term_off_i[r])
          a_r6_ded_literal: assert (term_o[r] == ded_i[1]) else $error("R6 row %0d", r);
        if ($countones(slice) == 1 && slice[N_COLS/2] && !term_off_i[r] && mode_i[1])
          a_r7_reg_feedback: assert (term_o[r] == fb_i[0]) else $error("R7 row %0d", r);
      end
    end
  end
endmodule

bind pta_term_array pta_term_array_chk #(
  .N_CELLS        (N_CELLS),
  .TERMS_PER_CELL (TERMS_PER_CELL)
) u_chk (.*);

// File: tb/pta_term_array_test.sv
module pta_term_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC   = 8;
  localparam int NR   = 64;
  localparam int NCOL = 32;
  localparam int NF   = NR * NCOL;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NF-1:0]   fuse;
  logic [NR-1:0]   off;
  logic [1:0]      mode;
  logic [NC+1:0]   ded;
  logic [NC-1:0]   fb;
  logic [NR-1:0]   term;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pta_term_array uut (
    .and_fuse_i (fuse),
    .term_off_i (off),
    .mode_i     (mode),
    .ded_i      (ded),
    .fb_i       (fb),
    .term_o     (term)
  );

  // array input j as stated in R6..R9
  function automatic logic arr_in(int j);
    int k;
    if (j < NC) return ded[j+1];
    k = j - NC;
    if (mode[1]) return fb[k];
    if (k == 0) return ded[0];
    if (k == NC-1) return ded[NC+1];
    if (mode == 2'b01) return fb[k];
    if (k < NC/2) return fb[k-1];
    return fb[k+1];
  endfunction

  function automatic logic [NR-1:0] model();
    logic [NR-1:0] e;
    logic p, l;
    for (int r = 0; r < NR; r++) begin
      p = 1'b1;
      for (int c = 0; c < NCOL; c++) begin
        if (fuse[r*NCOL + c]) begin
          l = arr_in(c/2) ^ c[0];
          p = p & l;
        end
      end
      e[r] = p & ~off[r];
    end
    return e;
  endfunction

  task automatic check_vec(string tag);
    logic [NR-1:0] e;
    @(negedge clk);
    #1;
    e = model();
    n_vec++;
    if (term !== e) begin
      n_bad++;
      $display("FAIL %s: term=%h expected=%h", tag, term, e);
    end
  endtask

  task automatic check_eq(string tag, logic [NR-1:0] e);
    @(negedge clk);
    #1;
    n_vec++;
    if (term !== e) begin
      n_bad++;
      $display("FAIL %s: term=%h expected=%h", tag, term, e);
    end
  endtask

  task automatic rand_pins();
    ded = NC'($urandom) | ((NC+2)'($urandom) << NC);
    fb  = NC'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NR-1:0] keep;
    fuse = '1; off = '0; mode = 2'b00; ded = '0; fb = '0;

    // R2: all intact reads zero in every mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rand_pins();
      check_eq("R2 all intact", '0);
    end

    // R3 / R4: all blown, then disables
    fuse = '0;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rand_pins();
      check_eq("R3 all blown", '1);
    end
    for (int i = 0; i < 20; i++) begin
      off = {32'($urandom), 32'($urandom)};
      rand_pins();
      check_eq("R4 disable", ~off);
    end
    off = '0;

    // R5: one blown row among intact rows
    for (int r = 0; r < NR; r++) begin
      fuse = '1;
      fuse[r*NCOL +: NCOL] = '0;
      rand_pins();
      check_eq("R5 row placement", NR'(1) << r);
    end

    // R1/R6..R9: rows read out single literals
    fuse = '0;
    for (int j = 0; j < 16; j++) begin
      fuse[j*NCOL + 2*j]        = 1'b1;
      fuse[(16+j)*NCOL + 2*j+1] = 1'b1;
    end
    for (int r = 32; r < NR; r++) begin
      fuse[r*NCOL + $urandom_range(0, 31)] = 1'b1;
      fuse[r*NCOL + $urandom_range(0, 31)] = 1'b1;
    end
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int i = 0; i < 300; i++) begin
        rand_pins();
        if (m == 0)      check_vec("R9 simple route");
        else if (m == 1) check_vec("R8 complex route");
        else             check_vec("R7 registered route");
      end
      // R6: dedicated pins checked directly via rows 0..7
      rand_pins();
      @(negedge clk); #1;
      n_vec++;
      if (term[7:0] !== ded[8:1]) begin
        n_bad++;
        $display("FAIL R6: term=%h expected=%h", term[7:0], ded[8:1]);
      end
      // unused pins in this mode leave every term unchanged
      for (int i = 0; i < 20; i++) begin
        rand_pins();
        @(negedge clk); #1;
        keep = term;
        if (m == 0)      fb[4:3] = ~fb[4:3];
        else if (m == 1) begin fb[0] = ~fb[0]; fb[7] = ~fb[7]; end
        else             begin ded[0] = ~ded[0]; ded[9] = ~ded[9]; end
        if (m == 0)      check_eq("R9 inner cells ignored", keep);
        else if (m == 1) check_eq("R8 outer feedback ignored", keep);
        else             check_eq("R7 outer pins ignored", keep);
      end
    end

    // R1: sparse random fuse maps against the model
    for (int p = 0; p < 200; p++) begin
      fuse = '0;
      for (int r = 0; r < NR; r++)
        for (int k = 0; k < int'($urandom_range(2, 5)); k++)
          fuse[r*NCOL + $urandom_range(0, 31)] = 1'b1;
      off = {32'($urandom), 32'($urandom)} & {32'($urandom), 32'($urandom)}
            & {32'($urandom), 32'($urandom)};
      for (int i = 0; i < 10; i++) begin
        mode = 2'($urandom);
        rand_pins();
        check_vec("R1 random map");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule